// File: doc/BRIEF.md
# Immediate-Operand SIMD Vector ALU

This block is a 128-bit vector execution unit for operations that combine one register vector with an immediate. The immediate is sign-extended and copied into every lane of the operation's granularity: 32-bit word, 16-bit halfword or 8-bit byte. The lanewise operations are bitwise OR, AND and XOR, add, subtract-from-immediate, signed greater-than compare and equality compare. Two further operations complete the set. A load-address operation broadcasts a zero-extended 18-bit immediate into every word. A bit select merges two vectors under a third vector that acts as a mask.

A request is presented for one cycle with `req_valid`, a 5-bit opcode, the source vectors and the three immediate fields. The registered result appears on the next clock edge. An opcode outside the supported set raises the illegal flag instead and leaves the previous result in place. Lane 0 is the most significant lane of the vector. The lanes are treated identically, so lane order affects only how a result is read.

Top module: `vimm_alu`

## Requirements
- R1: Word forms sign-extend `imm10` to 32 bits and replicate it into all four word lanes. Halfword forms sign-extend `imm10` to 16 bits and replicate it into all eight halfword lanes.
- R2: Byte forms ignore `imm10` and replicate `imm8` into all sixteen byte lanes.
- R3: The bitwise operations combine `src_a` with the replicated immediate. The opcodes are OR at 0/1/2, AND at 3/4/5 and XOR at 6/7/8, where each group of three means word, halfword and byte.
- R4: Opcode 9 (word) and opcode 10 (halfword) add the replicated immediate to each lane of `src_a`, modulo the lane width.
- R5: Opcode 11 (word) and opcode 12 (halfword) compute the replicated immediate minus each lane of `src_a`, modulo the lane width.
- R6: Opcodes 13/14/15 (word/halfword/byte) set a lane to all ones when the signed `src_a` lane is greater than the signed immediate, and to all zeros otherwise.
- R7: Opcodes 16/17/18 (word/halfword/byte) set a lane to all ones when the `src_a` lane equals the immediate, and to all zeros otherwise.
- R8: Opcode 19 writes `imm18`, zero-extended to 32 bits, into every word lane. All source vectors are ignored.
- R9: Opcode 20 takes each result bit from `src_b` where `src_mask` is 1 and from `src_a` where it is 0.
- R10: A legal request with `req_valid` high produces `res_valid` high and the new result one cycle later. In a cycle without a request, `res_valid` and `res_illegal` are low on the next cycle.
- R11: A request with an opcode from 21 to 31 raises `res_illegal` one cycle later, with `res_valid` low and `res_data` unchanged.
- R12: While `rst_n` is low, a clock edge clears `res_data`, `res_valid` and `res_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| opcode | input | 5 | Operation code |
| src_a | input | 128 | Register operand; the data input of select |
| src_b | input | 128 | Second operand of select |
| src_mask | input | 128 | Bit mask of select |
| imm10 | input | 10 | Signed immediate for word and halfword forms |
| imm8 | input | 8 | Immediate for byte forms |
| imm18 | input | 18 | Immediate for load-address |
| res_data | output | 128 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after a legal request |
| res_illegal | output | 1 | Illegal opcode seen on the previous request |

## Verification
The bench goes after the extreme immediates -512 and +511 and the byte immediate 0x80. A design that zero-extended `imm10` would give wrong upper bits in every lane for -512. A design that fed `imm10` to the byte forms would disagree wherever the two fields differ. Compare operands that differ only in the sign bit expose an unsigned comparison. Subtract-from cases with a known direction catch swapped operands, and lane-boundary sums catch carries that leak between lanes. Illegal opcodes issued right after a legal result catch a design that overwrites or validates the held result.

// File: rtl/vimm_pkg.sv
// Package: shared widths, opcode encoding and decoded-operation type
// for the immediate-operand vector ALU.
// Assumes the vector width is a multiple of 32.
package vimm_pkg;

    localparam int IMM10_W = 10;
    localparam int IMM8_W  = 8;
    localparam int IMM18_W = 18;
    localparam int OP_W    = 5;

    // Opcode encoding; values 21..31 are illegal.
    typedef enum logic [OP_W-1:0] {
        OP_OR_W   = 5'd0,  OP_OR_H   = 5'd1,  OP_OR_B   = 5'd2,
        OP_AND_W  = 5'd3,  OP_AND_H  = 5'd4,  OP_AND_B  = 5'd5,
        OP_XOR_W  = 5'd6,  OP_XOR_H  = 5'd7,  OP_XOR_B  = 5'd8,
        OP_ADD_W  = 5'd9,  OP_ADD_H  = 5'd10,
        OP_SUBF_W = 5'd11, OP_SUBF_H = 5'd12,
        OP_CGT_W  = 5'd13, OP_CGT_H  = 5'd14, OP_CGT_B  = 5'd15,
        OP_CEQ_W  = 5'd16, OP_CEQ_H  = 5'd17, OP_CEQ_B  = 5'd18,
        OP_LDA    = 5'd19,
        OP_SEL    = 5'd20
    } op_e;

    localparam logic [OP_W-1:0] OP_LAST = 5'd20;

    // Lane granularity of an operation.
    typedef enum logic [1:0] {
        GR_WORD = 2'd0,
        GR_HALF = 2'd1,
        GR_BYTE = 2'd2
    } gran_e;

    // Functional class of an operation.
    typedef enum logic [3:0] {
        K_OR, K_AND, K_XOR, K_ADD, K_SUBF, K_CGT, K_CEQ, K_LDA, K_SEL
    } kind_e;

    typedef struct packed {
        logic  legal;
        kind_e kind;
        gran_e gran;
    } dec_t;

endpackage

// File: rtl/vimm_decode.sv
// Module: vimm_decode
// Maps a raw opcode onto an operation class, a lane granularity and a
// legality flag. Purely combinational; assumes the encoding in vimm_pkg.
module vimm_decode
    import vimm_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);

    // Translate the opcode into class and granularity.
    always_comb begin
        dec.legal = 1'b1;
        dec.kind  = K_OR;
        dec.gran  = GR_WORD;
        case (opcode)
            OP_OR_W:   begin dec.kind = K_OR;   dec.gran = GR_WORD; end
            OP_OR_H:   begin dec.kind = K_OR;   dec.gran = GR_HALF; end
            OP_OR_B:   begin dec.kind = K_OR;   dec.gran = GR_BYTE; end
            OP_AND_W:  begin dec.kind = K_AND;  dec.gran = GR_WORD; end
            OP_AND_H:  begin dec.kind = K_AND;  dec.gran = GR_HALF; end
            OP_AND_B:  begin dec.kind = K_AND;  dec.gran = GR_BYTE; end
            OP_XOR_W:  begin dec.kind = K_XOR;  dec.gran = GR_WORD; end
            OP_XOR_H:  begin dec.kind = K_XOR;  dec.gran = GR_HALF; end
            OP_XOR_B:  begin dec.kind = K_XOR;  dec.gran = GR_BYTE; end
            OP_ADD_W:  begin dec.kind = K_ADD;  dec.gran = GR_WORD; end
            OP_ADD_H:  begin dec.kind = K_ADD;  dec.gran = GR_HALF; end
            OP_SUBF_W: begin dec.kind = K_SUBF; dec.gran = GR_WORD; end
            OP_SUBF_H: begin dec.kind = K_SUBF; dec.gran = GR_HALF; end
            OP_CGT_W:  begin dec.kind = K_CGT;  dec.gran = GR_WORD; end
            OP_CGT_H:  begin dec.kind = K_CGT;  dec.gran = GR_HALF; end
            OP_CGT_B:  begin dec.kind = K_CGT;  dec.gran = GR_BYTE; end
            OP_CEQ_W:  begin dec.kind = K_CEQ;  dec.gran = GR_WORD; end
            OP_CEQ_H:  begin dec.kind = K_CEQ;  dec.gran = GR_HALF; end
            OP_CEQ_B:  begin dec.kind = K_CEQ;  dec.gran = GR_BYTE; end
            OP_LDA:    begin dec.kind = K_LDA;  dec.gran = GR_WORD; end
            OP_SEL:    begin dec.kind = K_SEL;  dec.gran = GR_WORD; end
            default:   dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/vimm_replicate.sv
// Module: vimm_replicate
// Builds the replicated immediate vectors for all three granularities
// and the load-address broadcast. Assumes VEC_W is a multiple of 32.
module vimm_replicate
    import vimm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [IMM10_W-1:0] imm10,
    input  logic [IMM8_W-1:0]  imm8,
    input  logic [IMM18_W-1:0] imm18,
    output logic [VEC_W-1:0]   rep_word,
    output logic [VEC_W-1:0]   rep_half,
    output logic [VEC_W-1:0]   rep_byte,
    output logic [VEC_W-1:0]   rep_addr
);

    localparam int N_WORD = VEC_W / 32;
    localparam int N_HALF = VEC_W / 16;
    localparam int N_BYTE = VEC_W / 8;

    logic [31:0] word_imm;
    logic [15:0] half_imm;
    logic [31:0] addr_imm;

    // Sign-extend the short immediate to each lane width; zero-extend the address one.
    always_comb begin
        word_imm = {{(32-IMM10_W){imm10[IMM10_W-1]}}, imm10};
        half_imm = {{(16-IMM10_W){imm10[IMM10_W-1]}}, imm10};
        addr_imm = {{(32-IMM18_W){1'b0}}, imm18};
    end

    for (genvar w = 0; w < N_WORD; w++) begin : g_word
        assign rep_word[w*32 +: 32] = word_imm;
        assign rep_addr[w*32 +: 32] = addr_imm;
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign rep_half[h*16 +: 16] = half_imm;
    end

    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
        assign rep_byte[b*8 +: 8] = imm8;
    end

endmodule

// File: rtl/vimm_lane_arith.sv
// Module: vimm_lane_arith
// Lanewise add, subtract-from, signed greater-than and equality for one
// lane width. Lanes are independent: no carry crosses a lane boundary.
// Assumes VEC_W is a multiple of LANE_W.
module vimm_lane_arith #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32
) (
    input  logic [VEC_W-1:0] opnd,
    input  logic [VEC_W-1:0] kval,
    output logic [VEC_W-1:0] sum,
    output logic [VEC_W-1:0] diff,
    output logic [VEC_W-1:0] gt_mask,
    output logic [VEC_W-1:0] eq_mask
);

    localparam int N_LANE = VEC_W / LANE_W;

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] k_l;

        assign a_l = opnd[l*LANE_W +: LANE_W];
        assign k_l = kval[l*LANE_W +: LANE_W];

        // Per-lane arithmetic and compare masks.
        always_comb begin
            sum[l*LANE_W +: LANE_W]     = a_l + k_l;
            diff[l*LANE_W +: LANE_W]    = k_l - a_l;
            gt_mask[l*LANE_W +: LANE_W] = {LANE_W{$signed(a_l) > $signed(k_l)}};
            eq_mask[l*LANE_W +: LANE_W] = {LANE_W{a_l == k_l}};
        end
    end

endmodule

// File: rtl/vimm_alu.sv
// Module: vimm_alu (top)
// Immediate-operand vector ALU: decodes the opcode, expands the
// immediates, evaluates all lanewise results for each granularity and
// registers the selected one. Legal requests give res_valid one cycle
// later; illegal ones give res_illegal and hold res_data.
// Assumes VEC_W is a multiple of 32; lane 0 is the most significant lane.
module vimm_alu
    import vimm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [OP_W-1:0]    opcode,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   src_mask,
    input  logic [IMM10_W-1:0] imm10,
    input  logic [IMM8_W-1:0]  imm8,
    input  logic [IMM18_W-1:0] imm18,
    output logic [VEC_W-1:0]   res_data,
    output logic               res_valid,
    output logic               res_illegal
);

    localparam int N_GRAN = 3;

    dec_t             dec;
    logic [VEC_W-1:0] rep_word, rep_half, rep_byte, rep_addr;
    logic [VEC_W-1:0] rep_vec  [N_GRAN];
    logic [VEC_W-1:0] sum_vec  [N_GRAN];
    logic [VEC_W-1:0] diff_vec [N_GRAN];
    logic [VEC_W-1:0] gt_vec   [N_GRAN];
    logic [VEC_W-1:0] eq_vec   [N_GRAN];
    logic [VEC_W-1:0] kval;
    logic [VEC_W-1:0] nxt_data;

    vimm_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    vimm_replicate #(.VEC_W(VEC_W)) u_replicate (
        .imm10    (imm10),
        .imm8     (imm8),
        .imm18    (imm18),
        .rep_word (rep_word),
        .rep_half (rep_half),
        .rep_byte (rep_byte),
        .rep_addr (rep_addr)
    );

    assign rep_vec[0] = rep_word;
    assign rep_vec[1] = rep_half;
    assign rep_vec[2] = rep_byte;

    // One lane unit per granularity: 32, 16 and 8 bits.
    for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
        localparam int LW = 32 >> g;
        vimm_lane_arith #(.VEC_W(VEC_W), .LANE_W(LW)) u_lanes (
            .opnd    (src_a),
            .kval    (rep_vec[g]),
            .sum     (sum_vec[g]),
            .diff    (diff_vec[g]),
            .gt_mask (gt_vec[g]),
            .eq_mask (eq_vec[g])
        );
    end

    // Pick the replicated immediate matching the decoded granularity.
    always_comb begin
        case (dec.gran)
            GR_HALF: kval = rep_vec[1];
            GR_BYTE: kval = rep_vec[2];
            default: kval = rep_vec[0];
        endcase
    end

    // Choose the result for the decoded operation class.
    always_comb begin
        nxt_data = src_a | kval;
        case (dec.kind)
            K_OR:  nxt_data = src_a | kval;
            K_AND: nxt_data = src_a & kval;
            K_XOR: nxt_data = src_a ^ kval;
            K_ADD: nxt_data = (dec.gran == GR_HALF) ? sum_vec[1] : sum_vec[0];
            K_SUBF: nxt_data = (dec.gran == GR_HALF) ? diff_vec[1] : diff_vec[0];
            K_CGT: begin
                case (dec.gran)
                    GR_HALF: nxt_data = gt_vec[1];
                    GR_BYTE: nxt_data = gt_vec[2];
                    default: nxt_data = gt_vec[0];
                endcase
            end
            K_CEQ: begin
                case (dec.gran)
                    GR_HALF: nxt_data = eq_vec[1];
                    GR_BYTE: nxt_data = eq_vec[2];
                    default: nxt_data = eq_vec[0];
                endcase
            end
            K_LDA: nxt_data = rep_addr;
            K_SEL: nxt_data = (src_mask & src_b) | (~src_mask & src_a);
            default: nxt_data = src_a;
        endcase
    end

    // Result register with the valid and illegal flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data    <= '0;
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
        end else begin
            res_valid   <= req_valid & dec.legal;
            res_illegal <= req_valid & ~dec.legal;
            if (req_valid && dec.legal) begin
                res_data <= nxt_data;
            end
        end
    end

endmodule

// File: rtl/vimm_alu_chk.sv
// Module: vimm_alu_chk
// Checker for vimm_alu, attached by bind: result timing, illegal handling,
// load-address and select forms. Observes ports only.
module vimm_alu_chk
    import vimm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [OP_W-1:0]    opcode,
    input logic [VEC_W-1:0]   src_a,
    input logic [VEC_W-1:0]   src_b,
    input logic [VEC_W-1:0]   src_mask,
    input logic [IMM18_W-1:0] imm18,
    input logic [VEC_W-1:0]   res_data,
    input logic               res_valid,
    input logic               res_illegal
);

    localparam int N_WORD = VEC_W / 32;

    AST_LEGAL_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode <= OP_LAST) |=> (res_valid && !res_illegal)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_illegal)); // R10

    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode > OP_LAST) |=> (res_illegal && !res_valid)); // R11

    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode > OP_LAST) |=> $stable(res_data)); // R11

    AST_LDA_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode == OP_LDA) |=>
        (res_data == {N_WORD{{(32-IMM18_W){1'b0}}, $past(imm18)}})); // R8

    AST_SEL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode == OP_SEL) |=>
        (res_data == (($past(src_mask) & $past(src_b)) | (~$past(src_mask) & $past(src_a))))); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_illegal)); // R11

endmodule

bind vimm_alu vimm_alu_chk #(.VEC_W(VEC_W)) u_vimm_alu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .opcode      (opcode),
    .src_a       (src_a),
    .src_b       (src_b),
    .src_mask    (src_mask),
    .imm18       (imm18),
    .res_data    (res_data),
    .res_valid   (res_valid),
    .res_illegal (res_illegal)
);

// File: tb/test_vimm_alu.sv
// Bench for vimm_alu: directed corner immediates plus seeded random
// requests, compared against a behavioural model written from the requirements.
module test_vimm_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [4:0]   opcode = '0;
    logic [127:0] src_a = '0, src_b = '0, src_mask = '0;
    logic [9:0]   imm10 = '0;
    logic [7:0]   imm8 = '0;
    logic [17:0]  imm18 = '0;
    logic [127:0] res_data;
    logic         res_valid, res_illegal;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vimm_alu i_vimm_alu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .src_mask(src_mask),
        .imm10(imm10), .imm8(imm8), .imm18(imm18),
        .res_data(res_data), .res_valid(res_valid), .res_illegal(res_illegal)
    );

    function automatic string req_of(int op);
        if (op <= 8)  return "R3";
        if (op <= 10) return "R4";
        if (op <= 12) return "R5";
        if (op <= 15) return "R6";
        if (op <= 18) return "R7";
        if (op == 19) return "R8";
        return "R9";
    endfunction

    // cls: 0 or, 1 and, 2 xor, 3 add, 4 subf, 5 cgt, 6 ceq
    function automatic logic [31:0] lane_model(int cls, logic [31:0] a, logic [31:0] k, int w);
        logic [31:0] m;
        logic signed [31:0] sa, sk;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        sa = 32'(signed'(a << (32 - w))) >>> (32 - w);
        sk = 32'(signed'(k << (32 - w))) >>> (32 - w);
        case (cls)
            0: return (a | k) & m;
            1: return (a & k) & m;
            2: return (a ^ k) & m;
            3: return (a + k) & m;
            4: return (k - a) & m;
            5: return (sa > sk) ? m : 32'd0;
            default: return ((a & m) == (k & m)) ? m : 32'd0;
        endcase
    endfunction

    function automatic logic [127:0] model(int op, logic [127:0] a, logic [127:0] b,
                                           logic [127:0] msk, logic [9:0] i10,
                                           logic [7:0] i8, logic [17:0] i18);
        logic [127:0] r;
        int cls, gran, w;
        logic [31:0] k;
        r = '0;
        if (op == 19) return {4{14'd0, i18}};
        if (op == 20) return (msk & b) | (~msk & a);
        if (op <= 8)       begin cls = op / 3; gran = op % 3; end
        else if (op <= 10) begin cls = 3; gran = op - 9; end
        else if (op <= 12) begin cls = 4; gran = op - 11; end
        else if (op <= 15) begin cls = 5; gran = op - 13; end
        else               begin cls = 6; gran = op - 16; end
        w = 32 >> gran;
        k = (gran == 2) ? {24'd0, i8} : 32'(signed'({{22{i10[9]}}, i10}));
        for (int l = 0; l < 128 / w; l++) begin
            logic [31:0] lv;
            lv = 32'(a >> (l * w));
            r = r | (128'(lane_model(cls, lv, k, w)) << (l * w));
        end
        return r;
    endfunction

    task automatic check(string rq, logic [127:0] act, logic [127:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(int op, logic [127:0] a, logic [127:0] b, logic [127:0] m,
                          logic [9:0] i10, logic [7:0] i8, logic [17:0] i18);
        logic [127:0] exp;
        @(negedge clk);
        req_valid = 1'b1; opcode = 5'(op); src_a = a; src_b = b; src_mask = m;
        imm10 = i10; imm8 = i8; imm18 = i18;
        exp = model(op, a, b, m, i10, i8, i18);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_of(op), res_data, exp, $sformatf("op %0d data", op));
        check("R10", {127'd0, res_valid}, 128'd1, $sformatf("op %0d valid", op));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] held;
        void'($urandom(32'h1234_5678));
        req_valid = 1'b1; opcode = 5'd20; src_a = '1;
        repeat (3) @(negedge clk);
        // R12: reset clears outputs even with a request pending
        check("R12", res_data, '0, "reset data");
        check("R12", {126'd0, res_valid, res_illegal}, '0, "reset flags");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {126'd0, res_valid, res_illegal}, '0, "idle flags");

        // R1 R2: extreme immediates for every legal opcode
        for (int op = 0; op <= 20; op++) begin
            run_op(op, 128'h8000_0000_7FFF_FFFF_FE00_01FF_0080_FF7F,
                   rnd128(), rnd128(), 10'h200, 8'h80, 18'h3FFFF);
            run_op(op, 128'h0000_01FF_01FF_01FF_7F80_8080_01FF_0000,
                   rnd128(), rnd128(), 10'h1FF, 8'h7F, 18'h00001);
            run_op(op, {16{8'h80}}, rnd128(), rnd128(), 10'h080, 8'h80, 18'h20000);
        end
        // R1: sign extension visible through OR on zero register
        run_op(0, '0, '0, '0, 10'h200, 8'h00, 18'h0);
        check("R1", res_data, {4{32'hFFFF_FE00}}, "word sign extend -512");
        run_op(1, '0, '0, '0, 10'h200, 8'h00, 18'h0);
        check("R1", res_data, {8{16'hFE00}}, "half sign extend -512");
        // R2: byte form ignores imm10
        run_op(2, '0, '0, '0, 10'h3FF, 8'h5A, 18'h0);
        check("R2", res_data, {16{8'h5A}}, "byte uses imm8");
        // R5: direction of subtract-from
        run_op(11, {4{32'd1}}, '0, '0, 10'd5, 8'd0, 18'd0);
        check("R5", res_data, {4{32'd4}}, "imm minus reg");
        // R8: sources ignored
        run_op(19, '1, '1, '1, 10'h3FF, 8'hFF, 18'h2ABCD);
        check("R8", res_data, {4{32'h0002_ABCD}}, "lda ignores sources");

        // random mix
        for (int i = 0; i < 600; i++) begin
            run_op(int'($urandom % 21), rnd128(), rnd128(), rnd128(),
                   10'($urandom), 8'($urandom), 18'($urandom));
        end

        // R11: illegal opcodes hold result and raise flag
        for (int op = 21; op <= 31; op++) begin
            run_op(19, rnd128(), '0, '0, 10'd0, 8'd0, 18'($urandom));
            held = res_data;
            @(negedge clk);
            req_valid = 1'b1; opcode = 5'(op); src_a = rnd128(); imm10 = 10'($urandom);
            @(negedge clk);
            req_valid = 1'b0;
            check("R11", res_data, held, $sformatf("illegal %0d holds data", op));
            check("R11", {126'd0, res_valid, res_illegal}, 128'd1,
                  $sformatf("illegal %0d flags", op));
            @(negedge clk);
            check("R10", {126'd0, res_valid, res_illegal}, '0, "flags clear after idle");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule